// File: doc/BRIEF.md
# UART receive status flag controller

This block keeps the receive-side status of a UART. An external receive shift engine delivers one pulse per finished frame, with the received word and the per-frame error indications: bad parity, bad stop bit, break, and noise seen during sampling. It also delivers a separate pulse when the line goes idle. The controller places each finished word in a single-word holding register and marks it as pending. It records overrun, noise, framing and parity errors, along with the idle condition. It combines these into one interrupt request under three enable inputs.

Software sees two registers through a simple read port: a status word and the held data word. The error and idle flags are sticky. They clear only through an ordered pair of accesses: a status read first arms the clear, and the next data read completes it. Two small state machines carry the ordering rules. One tracks whether that clear is armed. The other decides whether an idle pulse may raise the idle flag again.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status word reads 0, the held word reads 0, irq is 0, and the clear sequence is disarmed.
- R2: A frame-done pulse that finds the holding register empty stores the word and sets the pending bit. In that same edge it ORs the frame's parity, framing and noise indications into their flags.
- R3: A frame-done pulse that finds the holding register full, with no data read in that cycle, sets the overrun flag. The held word, the framing, parity and noise flags, and the pending bit are all left unchanged, so an overrun word never sets the framing flag.
- R4: Read address 0 returns the status word and address 1 returns the held word; any other address returns 0. Status bit positions: bit 0 parity, bit 1 framing, bit 2 noise, bit 3 overrun, bit 4 idle, bit 5 pending. All higher bits read 0.
- R5: Any data read clears the pending bit.
- R6: A status read moves the clear sequence from SEQ_DISARMED to SEQ_ARMED. Reads of other addresses and further status reads keep it there. The next data read clears the overrun, noise, framing and idle flags and returns the sequence to SEQ_DISARMED. A data read made while disarmed clears none of these flags.
- R7: The parity flag is cleared by the completing data read only if the pending bit was 1 at that read; otherwise it stays set.
- R8: With lin_slave at 1, a break indication does not set the framing flag, but a framing indication does. With lin_slave at 0, either indication sets it.
- R9: irq is 1 exactly when rx_ie is 1 and the pending or overrun bit is set, or par_ie is 1 and the parity flag is set, or idle_ie is 1 and the idle flag is set. Noise and framing flags never raise irq by themselves.
- R10: An idle pulse sets the idle flag only when a word has been stored since reset or since the idle flag was last set. The gate moves from IDL_WAIT_WORD to IDL_READY when a word is stored, and back to IDL_WAIT_WORD when an idle pulse is accepted.
- R11: A data read and a frame-done pulse in the same cycle consume the old word and store the new one. No overrun is flagged. When a flag is cleared and set in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_done | input | 1 | Frame finished pulse from the shift engine |
| ev_data | input | DW | Word carried by the finished frame |
| ev_parity_bad | input | 1 | Parity mismatch on the finished frame |
| ev_frame_bad | input | 1 | Stop bit missing on the finished frame |
| ev_break | input | 1 | Finished frame was a break |
| ev_noise | input | 1 | Noise seen while sampling the frame |
| ev_idle | input | 1 | Idle line pulse |
| lin_slave | input | 1 | Break does not count as framing error |
| rx_ie | input | 1 | Interrupt enable for pending word and overrun |
| par_ie | input | 1 | Interrupt enable for parity error |
| idle_ie | input | 1 | Interrupt enable for idle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| rd_addr | input | AW | Read address |
| rd_data | output | max(DW,6) | Read data, combinational from rd_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after words that arrive while the holding register is full, each carrying a framing error. A design that moved the new word in, or marked framing on the lost word, would show the wrong held word or a framing bit next to overrun. It breaks the clear sequence with a lone data read, interleaved reads of other addresses, and a completing read while nothing is pending. A design that cleared on any data read, disarmed on stray accesses, or dropped parity without a pending word would show missing flags. It also checks break frames in both modes, repeated idle pulses without a new word, and a data read that coincides with a new frame. Designs that got these wrong would show a stuck framing bit, a second idle flag, or a false overrun.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;

    // status word layout
    localparam int ST_PE   = 0;
    localparam int ST_FE   = 1;
    localparam int ST_NF   = 2;
    localparam int ST_OVR  = 3;
    localparam int ST_IDLE = 4;
    localparam int ST_RXNE = 5;
    localparam int ST_W    = 6;

    typedef enum logic {
        SEQ_DISARMED,
        SEQ_ARMED
    } seq_state_t;

    typedef enum logic {
        IDL_WAIT_WORD,
        IDL_READY
    } idle_state_t;

endpackage

// File: rtl/rx_clr_seq.sv
module rx_clr_seq
    import uart_rx_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic data_rd,
    output logic clr,
    output logic armed
);

    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_DISARMED: if (stat_rd) state_d = SEQ_ARMED;
            SEQ_ARMED:    if (data_rd) state_d = SEQ_DISARMED;
            default:      state_d = SEQ_DISARMED;
        endcase
    end

    always_comb begin
        clr   = 1'b0;
        armed = 1'b0;
        unique case (state_q)
            SEQ_DISARMED: ;
            SEQ_ARMED: begin
                armed = 1'b1;
                clr   = data_rd;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_done,
    input  logic [DW-1:0] ev_data,
    input  logic          ev_parity_bad,
    input  logic          ev_frame_bad,
    input  logic          ev_break,
    input  logic          ev_noise,
    input  logic          lin_slave,
    input  logic          data_rd,
    input  logic          clr,
    output logic [DW-1:0] hold_q,
    output logic          rxne_q,
    output logic          ovr_q,
    output logic          pe_q,
    output logic          fe_q,
    output logic          nf_q,
    output logic          load
);

    logic rxne_eff;
    logic ovr_ev;
    logic pe_clr;
    logic fe_set;

    always_comb begin
        rxne_eff = rxne_q & ~data_rd;       // a read in this cycle frees the register
        load     = ev_done & ~rxne_eff;
        ovr_ev   = ev_done &  rxne_eff;
        pe_clr   = clr & rxne_q;
        fe_set   = ev_frame_bad | (ev_break & ~lin_slave);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            rxne_q <= 1'b0;
            ovr_q  <= 1'b0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            nf_q   <= 1'b0;
        end else begin
            if (load) hold_q <= ev_data;
            rxne_q <= load | rxne_eff;
            ovr_q  <= (ovr_q & ~clr)    | ovr_ev;
            pe_q   <= (pe_q  & ~pe_clr) | (load & ev_parity_bad);
            fe_q   <= (fe_q  & ~clr)    | (load & fe_set);
            nf_q   <= (nf_q  & ~clr)    | (load & ev_noise);
        end
    end

endmodule

// File: rtl/rx_idle_gate.sv
module rx_idle_gate
    import uart_rx_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_idle,
    input  logic load,
    input  logic clr,
    output logic idle_q,
    output logic idle_ready
);

    idle_state_t state_q, state_d;
    logic        idle_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDL_WAIT_WORD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDL_WAIT_WORD: if (load) state_d = IDL_READY;
            IDL_READY:     if (ev_idle && !load) state_d = IDL_WAIT_WORD;
            default:       state_d = IDL_WAIT_WORD;
        endcase
    end

    always_comb begin
        idle_set   = 1'b0;
        idle_ready = 1'b0;
        unique case (state_q)
            IDL_WAIT_WORD: ;
            IDL_READY: begin
                idle_ready = 1'b1;
                idle_set   = ev_idle;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_q <= 1'b0;
        else        idle_q <= (idle_q & ~clr) | idle_set;
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_status_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 2,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1,
    localparam int RW       = (DW > ST_W) ? DW : ST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_done,
    input  logic [DW-1:0] ev_data,
    input  logic          ev_parity_bad,
    input  logic          ev_frame_bad,
    input  logic          ev_break,
    input  logic          ev_noise,
    input  logic          ev_idle,
    input  logic          lin_slave,
    input  logic          rx_ie,
    input  logic          par_ie,
    input  logic          idle_ie,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [RW-1:0] rd_data,
    output logic          irq
);

    logic            stat_rd;
    logic            data_rd;
    logic            clr_pulse;
    logic            seq_armed;
    logic [DW-1:0]   hold_q;
    logic            rxne_q, ovr_q, pe_q, fe_q, nf_q;
    logic            word_load;
    logic            idle_q;
    logic            idle_ready;
    logic [ST_W-1:0] status;

    always_comb begin
        stat_rd = rd_en && (rd_addr == AW'(STAT_ADDR));
        data_rd = rd_en && (rd_addr == AW'(DATA_ADDR));
    end

    rx_clr_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .clr     (clr_pulse),
        .armed   (seq_armed)
    );

    rx_hold #(.DW(DW)) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_done       (ev_done),
        .ev_data       (ev_data),
        .ev_parity_bad (ev_parity_bad),
        .ev_frame_bad  (ev_frame_bad),
        .ev_break      (ev_break),
        .ev_noise      (ev_noise),
        .lin_slave     (lin_slave),
        .data_rd       (data_rd),
        .clr           (clr_pulse),
        .hold_q        (hold_q),
        .rxne_q        (rxne_q),
        .ovr_q         (ovr_q),
        .pe_q          (pe_q),
        .fe_q          (fe_q),
        .nf_q          (nf_q),
        .load          (word_load)
    );

    rx_idle_gate u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_idle    (ev_idle),
        .load       (word_load),
        .clr        (clr_pulse),
        .idle_q     (idle_q),
        .idle_ready (idle_ready)
    );

    always_comb begin
        status          = '0;
        status[ST_PE]   = pe_q;
        status[ST_FE]   = fe_q;
        status[ST_NF]   = nf_q;
        status[ST_OVR]  = ovr_q;
        status[ST_IDLE] = idle_q;
        status[ST_RXNE] = rxne_q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(STAT_ADDR))      rd_data[ST_W-1:0] = status;
        else if (rd_addr == AW'(DATA_ADDR)) rd_data[DW-1:0]   = hold_q;
    end

    // noise and framing deliberately absent
    always_comb begin
        irq = (rx_ie   & (rxne_q | ovr_q))
            | (par_ie  & pe_q)
            | (idle_ie & idle_q);
    end

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_done,
    input logic          ev_frame_bad,
    input logic          ev_break,
    input logic          lin_slave,
    input logic          rx_ie,
    input logic          par_ie,
    input logic          idle_ie,
    input logic          irq,
    input logic          data_rd,
    input logic          clr,
    input logic [DW-1:0] hold,
    input logic          rxne,
    input logic          ovr,
    input logic          fe,
    input logic          idle_q,
    input logic          idle_ready
);

    // R3: full register plus new frame raises overrun
    p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rxne && ev_done && !data_rd) |=> ovr);

    // R3: held word survives an overrun
    p_ovr_keeps_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rxne && ev_done && !data_rd) |=> $stable(hold));

    // R3: overrun word leaves framing untouched
    p_ovr_no_fe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rxne && ev_done && !data_rd && !fe) |=> !fe);

    // R5: data read without a new word empties the register
    p_rd_clears_rxne_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !ev_done) |=> !rxne);

    // R6: overrun is sticky outside the clear sequence
    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr) |=> ovr);

    // R8: break in lin slave mode does not mark framing
    p_lin_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && !(rxne && !data_rd) && lin_slave && ev_break
         && !ev_frame_bad && (!fe || clr)) |=> !fe);

    // R9: all enables low keeps the request low
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !par_ie && !idle_ie) |-> !irq);

    // R9: pending word with its enable always requests
    p_irq_rxne_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && rxne) |-> irq);

    // R10: idle cannot rise while the gate waits for a word
    p_idle_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_ready && !idle_q) |=> !idle_q);

endmodule

bind uart_rx_status uart_rx_status_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_done      (ev_done),
    .ev_frame_bad (ev_frame_bad),
    .ev_break     (ev_break),
    .lin_slave    (lin_slave),
    .rx_ie        (rx_ie),
    .par_ie       (par_ie),
    .idle_ie      (idle_ie),
    .irq          (irq),
    .data_rd      (data_rd),
    .clr          (clr_pulse),
    .hold         (hold_q),
    .rxne         (rxne_q),
    .ovr          (ovr_q),
    .fe           (fe_q),
    .idle_q       (idle_q),
    .idle_ready   (idle_ready)
);

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;

    localparam int DW = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_done = 0, ev_parity_bad = 0, ev_frame_bad = 0;
    logic          ev_break = 0, ev_noise = 0, ev_idle = 0;
    logic [DW-1:0] ev_data = '0;
    logic          lin_slave = 0, rx_ie = 0, par_ie = 0, idle_ie = 0;
    logic          rd_en = 0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          irq;

    always #10 clk = ~clk;

    uart_rx_status #(.DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_data(ev_data),
        .ev_parity_bad(ev_parity_bad), .ev_frame_bad(ev_frame_bad),
        .ev_break(ev_break), .ev_noise(ev_noise), .ev_idle(ev_idle),
        .lin_slave(lin_slave), .rx_ie(rx_ie), .par_ie(par_ie), .idle_ie(idle_ie),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 0;
    logic cfg_lin = 0, cfg_rxie = 0, cfg_parie = 0, cfg_idleie = 0;
    logic [7:0] last_rd;

    // reference state
    logic       m_rxne, m_ovr, m_pe, m_fe, m_nf, m_idle, m_ready, m_armed;
    logic [7:0] m_data;

    function automatic logic [7:0] m_read(logic [1:0] a);
        if (a == 2'd0) return {2'b00, m_rxne, m_idle, m_ovr, m_nf, m_fe, m_pe};
        if (a == 2'd1) return m_data;
        return 8'h00;
    endfunction

    function automatic logic m_irq();
        return (rx_ie & (m_rxne | m_ovr)) | (par_ie & m_pe) | (idle_ie & m_idle);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_rxne = 0; m_ovr = 0; m_pe = 0; m_fe = 0; m_nf = 0;
        m_idle = 0; m_ready = 0; m_armed = 0; m_data = '0;
    endtask

    task automatic step(string tag, logic ren, logic [1:0] a, logic dn,
                        logic [7:0] d, logic pb, logic fb, logic bk,
                        logic nz, logic idl);
        logic srd, drd, clr, eff, ld, ov, iset;
        @(negedge clk);
        rd_en = ren; rd_addr = a; ev_done = dn; ev_data = d;
        ev_parity_bad = pb; ev_frame_bad = fb; ev_break = bk;
        ev_noise = nz; ev_idle = idl;
        lin_slave = cfg_lin; rx_ie = cfg_rxie; par_ie = cfg_parie; idle_ie = cfg_idleie;
        #1;
        last_rd = rd_data;
        chk({tag, " R4 read"}, rd_data, m_read(a));
        chk({tag, " R9 irq"}, {7'd0, irq}, {7'd0, m_irq()});
        srd  = ren && a == 2'd0;
        drd  = ren && a == 2'd1;
        clr  = drd && m_armed;
        eff  = m_rxne && !drd;
        ld   = dn && !eff;
        ov   = dn && eff;
        iset = idl && m_ready;
        m_pe   = (m_pe && !(clr && m_rxne)) || (ld && pb);
        m_ovr  = (m_ovr && !clr) || ov;
        m_fe   = (m_fe && !clr) || (ld && (fb || (bk && !cfg_lin)));
        m_nf   = (m_nf && !clr) || (ld && nz);
        m_idle = (m_idle && !clr) || iset;
        m_ready = ld ? 1'b1 : (iset ? 1'b0 : m_ready);
        if (ld) m_data = d;
        m_rxne = ld || eff;
        if (srd) m_armed = 1; else if (drd) m_armed = 0;
    endtask

    task automatic look(string tag, logic [1:0] a);
        step(tag, 0, a, 0, 8'h00, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(string tag, logic [1:0] a);
        step(tag, 1, a, 0, 8'h00, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_reset();
        cfg_rxie = 1; cfg_parie = 1; cfg_idleie = 1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        look("R1", 2'd0);
        chk("R1 status", last_rd, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        look("R1", 2'd1);
        chk("R1 data", last_rd, 8'h00);

        // R2: first word with bad parity
        step("R2", 0, 0, 1, 8'hA5, 1, 0, 0, 0, 0);
        look("R2", 2'd1);
        chk("R2 data", last_rd, 8'hA5);
        look("R2", 2'd0);
        chk("R2 status", last_rd, 8'h21);

        // R3: second word while full, with framing error
        step("R3", 0, 0, 1, 8'h3C, 0, 1, 0, 0, 0);
        look("R3", 2'd1);
        chk("R3 data kept", last_rd, 8'hA5);
        look("R3", 2'd0);
        chk("R3 ovr only", last_rd, 8'h29);

        // R5/R6: lone data read empties register but keeps flags
        rd("R6", 2'd1);
        look("R5", 2'd0);
        chk("R5 R6 lone data read", last_rd, 8'h09);

        // R6/R7: status, stray access, data read; parity stays (nothing pending)
        rd("R6", 2'd0);
        rd("R6", 2'd2);
        rd("R6", 2'd1);
        look("R7", 2'd0);
        chk("R6 R7 clear", last_rd, 8'h01);

        // R8: break in lin slave mode
        cfg_lin = 1;
        step("R8", 0, 0, 1, 8'h5A, 0, 0, 1, 0, 0);
        look("R8", 2'd0);
        chk("R8 lin break", last_rd, 8'h21);
        rd("R7", 2'd0);
        rd("R7", 2'd1);
        look("R7", 2'd0);
        chk("R7 parity cleared", last_rd, 8'h00);
        step("R8", 0, 0, 1, 8'h66, 0, 1, 0, 0, 0);
        look("R8", 2'd0);
        chk("R8 lin frame err", last_rd, 8'h22);
        cfg_lin = 0;
        rd("R8", 2'd0);
        rd("R8", 2'd1);
        step("R8", 0, 0, 1, 8'h67, 0, 0, 1, 0, 0);
        look("R8", 2'd0);
        chk("R8 normal break", last_rd, 8'h22);

        // R10: idle gating
        step("R10", 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
        look("R10", 2'd0);
        chk("R10 idle set", last_rd, 8'h32);
        rd("R10", 2'd0);
        rd("R10", 2'd1);
        step("R10", 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
        look("R10", 2'd0);
        chk("R10 idle blocked", last_rd, 8'h00);
        step("R10", 0, 0, 1, 8'h11, 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
        look("R10", 2'd0);
        chk("R10 idle rearmed", last_rd, 8'h30);

        // R11: data read coincides with a new frame
        step("R11", 1, 1, 1, 8'h77, 0, 0, 0, 0, 0);
        look("R11", 2'd1);
        chk("R11 new word", last_rd, 8'h77);
        look("R11", 2'd0);
        chk("R11 no overrun", last_rd & 8'h08, 8'h00);

        // R9: noise and framing alone do not request
        rd("R9", 2'd0);
        rd("R9", 2'd1);
        cfg_rxie = 0; cfg_parie = 1; cfg_idleie = 0;
        step("R9", 0, 0, 1, 8'h42, 0, 1, 0, 1, 0);
        look("R9", 2'd0);
        chk("R9 status", last_rd, 8'h26);
        chk("R9 quiet irq", {7'd0, irq}, 8'h00);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[31:28] == 4'd0) begin
                cfg_lin = r[0]; cfg_rxie = r[1]; cfg_parie = r[2]; cfg_idleie = r[3];
            end
            step("RND", r[4] & r[5], r[7:6], r[8] & r[9], r[17:10],
                 r[18], r[19] & r[20], r[21] & r[22], r[23] & r[24], r[25] & r[26]);
        end

        finished = 1;
        finish_run();
    end

endmodule